// File: doc/BRIEF.md
# Sticky Loss-of-Signal Interrupt Aggregator

This block gathers loss-of-signal levels from three receiver ports of four lanes each and turns them into one level interrupt for control software. Each port owns one status byte. Its low half mirrors the present loss state of each enabled lane in the same cycle. Its high half latches each loss event until software clears it. The interrupt output is high while any status bit of any enabled lane, live or latched, is set.

Software reaches the block through a byte-wide register port. Reads are combinational from the address. A write takes effect on the clock edge at which the write strobe is high. Writing zero to a status byte clears its latched half. Next to each status byte is a four-bit lane-inversion setting. The block only stores it and presents it on an output for the receiver to use. All pins are plain levels with no handshake, because no data stream passes through the block.

Top module: `los_irq_hub`

## Requirements
- R1: After reset every latched bit and every inversion setting is 0. With no lane reporting loss, every register reads 0x00 and `irq` is 0.
- R2: Status byte bits [3:0] at 0x45 (port 0), 0x85 (port 1) and 0xC5 (port 2) equal, in the same cycle, `los_in & rx_en` for lanes 3..0 of that port. Port p lane l uses flat index 4p+l.
- R3: Status bit [4+l] sets at the edge where lane l of that port is enabled and reports loss. Once set it holds after the loss ends.
- R4: A write of 0x00 to a status address clears that port's latched bits at that edge. A write of any nonzero value to a status address leaves them unchanged.
- R5: A lane that is enabled and reporting loss at the edge of a clearing write keeps its latched bit set.
- R6: A lane whose `rx_en` bit is 0 reads 0 in both its live and latched bits and does not raise `irq`. At each edge where it is disabled, its latched bit is cleared, so it is 0 when the lane is enabled again.
- R7: `irq` is the OR of all status bits of all three ports. Once high it stays high until every latched bit has been cleared and every live bit reads 0.
- R8: Inversion settings at 0x44, 0x84 and 0xC4 are read/write in bits [3:0], with bits [7:4] reading 0. Port p drives `swap_cfg[4p+3:4p]`.
- R9: Any other address reads 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| los_in | input | 12 | Per-lane loss-of-signal level, index 4*port+lane |
| rx_en | input | 12 | Per-lane receiver enable, same indexing |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| irq | output | 1 | Level interrupt |
| swap_cfg | output | 12 | Lane inversion settings, index 4*port+lane |

## Verification
The bench targets a clearing write that coincides with a live loss. A design that cleared unconditionally would lose the event and let `irq` drop while the lane is still failing. It writes nonzero values to a status byte, which a design decoding only the address would wrongly treat as a clear. It disables a lane that holds a latched bit, to catch a design that leaks that bit into `irq` or keeps it through re-enable. It also writes to unmapped and inversion addresses to catch decode aliasing between neighbouring registers.

// File: rtl/los_pkg.sv
package los_pkg;
  // Port p occupies the 64-byte window starting at (p+1)*64.
  localparam logic [7:0] STAT_OFS = 8'h05;
  localparam logic [7:0] SWAP_OFS = 8'h04;

  function automatic logic [7:0] stat_addr(input int p);
    return 8'((p + 1) * 64) | STAT_OFS;
  endfunction

  function automatic logic [7:0] swap_addr(input int p);
    return 8'((p + 1) * 64) | SWAP_OFS;
  endfunction
endpackage

// File: rtl/los_port_status.sv
module los_port_status #(
  parameter int NLANES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLANES-1:0] los,
  input  logic [NLANES-1:0] en,
  input  logic              clr,
  output logic [NLANES-1:0] live_o,
  output logic [NLANES-1:0] stk_o
);
  logic [NLANES-1:0] stk_q;
  logic [NLANES-1:0] stk_d;

  assign live_o = los & en;
  // A clear keeps lanes still in loss; disabled lanes drop their latch.
  assign stk_d  = ((clr ? '0 : stk_q) | live_o) & en;
  assign stk_o  = stk_q & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stk_q <= '0;
    else        stk_q <= stk_d;
  end
endmodule

// File: rtl/los_swap_reg.sv
module los_swap_reg #(
  parameter int NLANES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [NLANES-1:0] wd,
  output logic [NLANES-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wd;
  end
endmodule

// File: rtl/los_irq_hub.sv
module los_irq_hub #(
  parameter int NPORTS = 3,
  parameter int NLANES = 4,
  parameter int AW     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS*NLANES-1:0] los_in,
  input  logic [NPORTS*NLANES-1:0] rx_en,
  input  logic [AW-1:0]            reg_addr,
  input  logic                     reg_wr,
  input  logic [2*NLANES-1:0]      reg_wdata,
  output logic [2*NLANES-1:0]      reg_rdata,
  output logic                     irq,
  output logic [NPORTS*NLANES-1:0] swap_cfg
);
  import los_pkg::*;

  localparam int DW = 2 * NLANES;

  logic [NLANES-1:0] live_w [NPORTS];
  logic [NLANES-1:0] stk_w  [NPORTS];
  logic [NLANES-1:0] swp_w  [NPORTS];
  logic [NPORTS-1:0] sel_st;
  logic [NPORTS-1:0] sel_sw;
  logic [NPORTS-1:0] act_p;
  logic              wzero;

  assign wzero = (reg_wdata == '0);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign sel_st[p] = (reg_addr == AW'(stat_addr(p)));
    assign sel_sw[p] = (reg_addr == AW'(swap_addr(p)));

    los_port_status #(.NLANES(NLANES)) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .los    (los_in[p*NLANES +: NLANES]),
      .en     (rx_en[p*NLANES +: NLANES]),
      .clr    (reg_wr && sel_st[p] && wzero),
      .live_o (live_w[p]),
      .stk_o  (stk_w[p])
    );

    los_swap_reg #(.NLANES(NLANES)) u_swap (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_wr && sel_sw[p]),
      .wd    (reg_wdata[NLANES-1:0]),
      .q     (swp_w[p])
    );

    assign swap_cfg[p*NLANES +: NLANES] = swp_w[p];
    assign act_p[p] = |(live_w[p] | stk_w[p]);
  end

  assign irq = |act_p;

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (sel_st[p]) reg_rdata = reg_rdata | {stk_w[p], live_w[p]};
      if (sel_sw[p]) reg_rdata = reg_rdata | DW'(swp_w[p]);
    end
  end
endmodule

// File: rtl/los_irq_hub_chk.sv
module los_irq_hub_chk #(
  parameter int NPORTS = 3,
  parameter int NLANES = 4,
  parameter int AW     = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NPORTS*NLANES-1:0] los_in,
  input logic [NPORTS*NLANES-1:0] rx_en,
  input logic [AW-1:0]            reg_addr,
  input logic                     reg_wr,
  input logic [2*NLANES-1:0]      reg_rdata,
  input logic                     irq,
  input logic [NPORTS*NLANES-1:0] swap_cfg
);
  import los_pkg::*;

  logic mapped;
  logic [NLANES-1:0] live0;
  always_comb begin
    mapped = 1'b0;
    for (int p = 0; p < NPORTS; p++)
      if (reg_addr == AW'(stat_addr(p)) || reg_addr == AW'(swap_addr(p))) mapped = 1'b1;
  end
  assign live0 = los_in[NLANES-1:0] & rx_en[NLANES-1:0];

  // R2: live half of port 0 follows its lanes in the same cycle
  p_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(stat_addr(0))) |-> (reg_rdata[NLANES-1:0] == live0));

  // R6: fully disabled receivers never interrupt
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en == '0) |-> !irq);

  // R7: an enabled lane in loss forces the interrupt
  p_irq_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((los_in & rx_en) != '0) |-> irq);

  // R7: without a write or an enable change the interrupt cannot drop
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> (irq || (rx_en != $past(rx_en))));

  // R8: inversion settings change only on a write
  p_swap_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(swap_cfg));

  // R9: unmapped addresses read zero
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (reg_rdata == '0));
endmodule

bind los_irq_hub los_irq_hub_chk #(.NPORTS(NPORTS), .NLANES(NLANES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .los_in(los_in), .rx_en(rx_en), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_rdata(reg_rdata), .irq(irq), .swap_cfg(swap_cfg)
);

// File: tb/sim_los_irq_hub.sv
module sim_los_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] los_in = '0;
  logic [11:0] rx_en = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq;
  logic [11:0] swap_cfg;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  bit [3:0] m_stk [3];
  bit [3:0] m_swp [3];

  always #5 clk = ~clk;

  los_irq_hub u0 (
    .clk(clk), .rst_n(rst_n), .los_in(los_in), .rx_en(rx_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .swap_cfg(swap_cfg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit [7:0] exp_rd(input bit [7:0] a);
    for (int p = 0; p < 3; p++) begin
      bit [3:0] e = rx_en[p*4 +: 4];
      bit [3:0] l = los_in[p*4 +: 4];
      if (a == 8'((p + 1) * 64 + 5)) return {m_stk[p] & e, l & e};
      if (a == 8'((p + 1) * 64 + 4)) return {4'b0, m_swp[p]};
    end
    return 8'h00;
  endfunction

  function automatic bit exp_irq();
    bit r = 0;
    for (int p = 0; p < 3; p++)
      r |= |((m_stk[p] | los_in[p*4 +: 4]) & rx_en[p*4 +: 4]);
    return r;
  endfunction

  function automatic bit [11:0] exp_swp();
    return {m_swp[2], m_swp[1], m_swp[0]};
  endfunction

  task automatic model_edge();
    for (int p = 0; p < 3; p++) begin
      bit [3:0] live = los_in[p*4 +: 4] & rx_en[p*4 +: 4];
      bit clr = reg_wr && reg_addr == 8'((p + 1) * 64 + 5) && reg_wdata == 8'h00;
      m_stk[p] = ((clr ? 4'b0 : m_stk[p]) | live) & rx_en[p*4 +: 4];
      if (reg_wr && reg_addr == 8'((p + 1) * 64 + 4)) m_swp[p] = reg_wdata[3:0];
    end
  endtask

  // Apply inputs at the falling edge, check outputs, then let the rising edge act.
  task automatic cyc(input string tag, input bit [11:0] l, input bit [11:0] e,
                     input bit [7:0] a, input bit w, input bit [7:0] d);
    @(negedge clk);
    los_in = l; rx_en = e; reg_addr = a; reg_wr = w; reg_wdata = d;
    #1;
    chk(tag, reg_rdata, exp_rd(a));
    chk("R7 irq", irq, exp_irq());
    chk("R8 swap_cfg", swap_cfg, exp_swp());
    model_edge();
    @(posedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    bit [7:0] alist [7];
    for (int p = 0; p < 3; p++) begin m_stk[p] = 0; m_swp[p] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state at every mapped address
    cyc("R1 0x45", 12'h000, 12'hFFF, 8'h45, 0, 0);
    cyc("R1 0x85", 12'h000, 12'hFFF, 8'h85, 0, 0);
    cyc("R1 0xC5", 12'h000, 12'hFFF, 8'hC5, 0, 0);
    cyc("R1 0x44", 12'h000, 12'hFFF, 8'h44, 0, 0);
    chk("R1 irq", irq, 0);
    // R2/R3: live then latched
    cyc("R2 live", 12'h002, 12'hFFF, 8'h45, 0, 0);
    cyc("R3 hold", 12'h000, 12'hFFF, 8'h45, 0, 0);
    chk("R3 byte", reg_rdata, 8'h20);
    // R4: nonzero write keeps, zero write clears
    cyc("R4 nz", 12'h000, 12'hFFF, 8'h45, 1, 8'h5A);
    cyc("R4 kept", 12'h000, 12'hFFF, 8'h45, 1, 8'h00);
    cyc("R4 clr", 12'h000, 12'hFFF, 8'h45, 0, 0);
    chk("R4 byte", reg_rdata, 8'h00);
    chk("R4 irq", irq, 0);
    // R5: clear in the same cycle as an active loss
    cyc("R5 set", 12'h040, 12'hFFF, 8'h85, 1, 8'h00);
    cyc("R5 keep", 12'h000, 12'hFFF, 8'h85, 0, 0);
    chk("R5 byte", reg_rdata, 8'h40);
    cyc("R5 clr", 12'h000, 12'hFFF, 8'h85, 1, 8'h00);
    // R6: disable a lane holding a latch
    cyc("R6 set", 12'h100, 12'hFFF, 8'hC5, 0, 0);
    cyc("R6 dis", 12'h100, 12'hEFF, 8'hC5, 0, 0);
    chk("R6 irq", irq, 0);
    cyc("R6 re", 12'h000, 12'hFFF, 8'hC5, 0, 0);
    chk("R6 byte", reg_rdata, 8'h00);
    // R8: inversion registers
    cyc("R8 wr", 12'h000, 12'hFFF, 8'h84, 1, 8'hFF);
    cyc("R8 rd", 12'h000, 12'hFFF, 8'h84, 0, 0);
    chk("R8 byte", reg_rdata, 8'h0F);
    chk("R8 pins", swap_cfg, 12'h0F0);
    // R9: unmapped address
    cyc("R9 wr", 12'h000, 12'hFFF, 8'h46, 1, 8'h00);
    cyc("R9 rd", 12'h000, 12'hFFF, 8'h46, 0, 0);
    cyc("R9 swap", 12'h000, 12'hFFF, 8'h84, 0, 0);
    // Constrained random mix
    alist = '{8'h44, 8'h45, 8'h84, 8'h85, 8'hC4, 8'hC5, 8'h00};
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      bit [11:0] l = 0, e;
      bit [7:0] a, d;
      bit w;
      for (int b = 0; b < 12; b++) l[b] = ($urandom % 16) == 0;
      e = (($urandom % 8) == 0) ? 12'($urandom) : 12'hFFF;
      a = alist[$urandom % 7];
      if (a == 8'h00) a = 8'($urandom);
      w = ($urandom % 4) == 0;
      d = (($urandom % 2) == 0) ? 8'h00 : 8'($urandom);
      if (a[2:0] == 3'd5 && a[5:3] == 0 && a[7:6] != 0) cyc("R3 rand", l, e, a, w, d);
      else if (a[2:0] == 3'd4 && a[5:3] == 0 && a[7:6] != 0) cyc("R8 rand", l, e, a, w, d);
      else cyc("R9 rand", l, e, a, w, d);
    end
    summary();
  end
endmodule